// File: doc/BRIEF.md
# Single-Bit Shift Microoperation Register

This block is a W-bit register that applies exactly one operation per clock edge while its enable is high. A 3-bit operation code picks the operation:

- a parallel load from a data input;
- a one-place logical shift left or right, with zero fill;
- a one-place rotate left or right;
- a one-place arithmetic shift left or right;
- a hold.

On an arithmetic left shift the block raises a registered overflow flag if the sign bit changes. Any other enabled operation clears the flag.

It is intended as the working register of a small datapath. The controller presents an operation code together with the enable, and the result appears on the register output after the next rising clock edge. The synchronous reset is active high and clears both the register and the flag.

Top module: `shift_microop_reg`

## Requirements
- R1: A clock edge with `rst` high leaves `r_q` at all zeros and `ovf_q` at 0, whatever `en` is.
- R2: A clock edge with `rst` low and `en` low leaves both `r_q` and `ovf_q` unchanged, whatever the values of `op` and `din`.
- R3: Op code 3'b000 (load) puts `din` into `r_q`. Op code 3'b111 (hold) keeps `r_q`. Both clear `ovf_q`.
- R4: Op code 3'b001 (logical left) moves each bit up one place and puts 0 into bit 0. Example: 8'hA3 becomes 8'h46.
- R5: Op code 3'b010 (logical right) moves each bit down one place and puts 0 into the MSB. Example: 8'hA3 becomes 8'h51.
- R6: Op code 3'b011 (rotate left) moves the old MSB into bit 0. Example: 8'hA3 becomes 8'h47.
- R7: Op code 3'b100 (rotate right) moves the old bit 0 into the MSB. Example: 8'hA3 becomes 8'hD1.
- R8: Op code 3'b101 (arithmetic left) moves each bit up one place and puts 0 into bit 0. Example: 8'hFE (-2) becomes 8'hFC (-4).
- R9: Op code 3'b110 (arithmetic right) keeps the MSB and also copies it into the next bit down. Examples: 8'hFA (-6) becomes 8'hFD (-3), and 8'h04 becomes 8'h02.
- R10: After an enabled arithmetic left shift, `ovf_q` is 1 exactly when the new MSB differs from the old MSB. Example: 8'h40 gives overflow, 8'hE0 does not.
- R11: Any enabled operation other than arithmetic left sets `ovf_q` to 0. The operand on `din` has no effect on any operation other than load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Applies the selected operation on this edge |
| op | input | 3 | Operation code (see R3 to R10) |
| din | input | W | Parallel load value |
| r_q | output | W | Register contents |
| ovf_q | output | 1 | Overflow from the most recent enabled operation |

## Verification
Both results, the new register value and the overflow flag, are due one rising edge after the inputs are presented. No combinational path runs from the inputs to the outputs.

The bench changes its inputs on the falling edge and waits for the next rising edge. It then samples one nanosecond later, so each check sees the result of exactly one operation. Each table vector first loads a starting value and then applies one operation, so every vector checks a single edge in isolation. The directed tests add cycles with the enable low, to confirm that the outputs stay unchanged.

// File: rtl/shift_microop_pkg.sv
package shift_microop_pkg;

    typedef enum logic [2:0] {
        OP_LOAD = 3'b000,
        OP_LSL  = 3'b001,
        OP_LSR  = 3'b010,
        OP_ROL  = 3'b011,
        OP_ROR  = 3'b100,
        OP_ASL  = 3'b101,
        OP_ASR  = 3'b110,
        OP_HOLD = 3'b111
    } shop_e;

    // Bit entering the LSB on upward moves
    function automatic logic low_fill(input shop_e op, input logic msb);
        return (op == OP_ROL) ? msb : 1'b0;
    endfunction

    // Bit entering the MSB on downward moves
    function automatic logic high_fill(input shop_e op, input logic msb, input logic lsb);
        case (op)
            OP_ROR:  return lsb;
            OP_ASR:  return msb;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic moves_up(input shop_e op);
        return (op == OP_LSL) || (op == OP_ROL) || (op == OP_ASL);
    endfunction

    function automatic logic moves_down(input shop_e op);
        return (op == OP_LSR) || (op == OP_ROR) || (op == OP_ASR);
    endfunction

endpackage

// File: rtl/shift_core.sv
module shift_core
    import shift_microop_pkg::*;
#(
    parameter int W = 8
) (
    input  shop_e          op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   nxt,
    output logic           nxt_ovf
);
    localparam int MSB = W - 1;

    logic fill_lo;
    logic fill_hi;
    logic up;
    logic down;
    logic is_load;

    always_comb begin
        fill_lo = low_fill(op, cur[MSB]);
        fill_hi = high_fill(op, cur[MSB], cur[0]);
        up      = moves_up(op);
        down    = moves_down(op);
        is_load = (op == OP_LOAD);
    end

    // One three-way selector per bit, plus load
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic from_below;
        logic from_above;
        if (i == 0) begin : g_lo
            assign from_below = fill_lo;
        end else begin : g_lo_n
            assign from_below = cur[i-1];
        end
        if (i == MSB) begin : g_hi
            assign from_above = fill_hi;
        end else begin : g_hi_n
            assign from_above = cur[i+1];
        end
        always_comb begin
            if (is_load)    nxt[i] = din[i];
            else if (up)    nxt[i] = from_below;
            else if (down)  nxt[i] = from_above;
            else            nxt[i] = cur[i];
        end
    end

    // On an upward move, the new sign bit is the old bit MSB-1
    assign nxt_ovf = (op == OP_ASL) && (cur[MSB] != cur[MSB-1]);

endmodule

// File: rtl/shift_state.sv
module shift_state #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] nxt,
    input  logic         nxt_ovf,
    output logic [W-1:0] r_q,
    output logic         ovf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            r_q   <= '0;
            ovf_q <= 1'b0;
        end else if (en) begin
            r_q   <= nxt;
            ovf_q <= nxt_ovf;
        end
    end
endmodule

// File: rtl/shift_microop_reg.sv
module shift_microop_reg
    import shift_microop_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [2:0]   op,
    input  logic [W-1:0] din,
    output logic [W-1:0] r_q,
    output logic         ovf_q
);
    logic [W-1:0] nxt;
    logic         nxt_ovf;
    shop_e        op_e;

    assign op_e = shop_e'(op);

    shift_core #(.W(W)) u_core (
        .op      (op_e),
        .cur     (r_q),
        .din     (din),
        .nxt     (nxt),
        .nxt_ovf (nxt_ovf)
    );

    shift_state #(.W(W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .nxt     (nxt),
        .nxt_ovf (nxt_ovf),
        .r_q     (r_q),
        .ovf_q   (ovf_q)
    );
endmodule

// File: rtl/shift_microop_chk.sv
module shift_microop_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [2:0]   op,
    input logic [W-1:0] din,
    input logic [W-1:0] r_q,
    input logic         ovf_q
);
    localparam int M = W - 1;
    logic act;
    assign act = en && !rst;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (r_q == '0) && !ovf_q);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(r_q) && $stable(ovf_q));

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b000) |=> (r_q == $past(din)) && !ovf_q);

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b111) |=> $stable(r_q) && !ovf_q);

    a_r4_lsl: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b001) |=> r_q == {$past(r_q[M-1:0]), 1'b0});

    a_r5_lsr: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b010) |=> r_q == {1'b0, $past(r_q[M:1])});

    a_r6_rol: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b011) |=> r_q == {$past(r_q[M-1:0]), $past(r_q[M])});

    a_r7_ror: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b100) |=> r_q == {$past(r_q[0]), $past(r_q[M:1])});

    a_r8_asl: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b101) |=> r_q == {$past(r_q[M-1:0]), 1'b0});

    a_r9_asr: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b110) |=> r_q == {$past(r_q[M]), $past(r_q[M:1])});

    a_r10_asl_ovf: assert property (@(posedge clk) disable iff (rst)
        (act && op == 3'b101) |=> ovf_q == (r_q[M] != $past(r_q[M])));

    a_r11_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        (act && op != 3'b101) |=> !ovf_q);
endmodule

bind shift_microop_reg shift_microop_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .op    (op),
    .din   (din),
    .r_q   (r_q),
    .ovf_q (ovf_q)
);

// File: tb/sim_shift_microop_reg.sv
`timescale 1ns/1ps
module sim_shift_microop_reg;
    localparam int W = 8;
    localparam int NV = 22;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] din = '0;
    logic [W-1:0] r_q;
    logic         ovf_q;
    int ntests = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    shift_microop_reg #(.W(W)) u0 (
        .clk(clk), .rst(rst), .en(en), .op(op), .din(din),
        .r_q(r_q), .ovf_q(ovf_q)
    );

    // Vector layout: {op[2:0], start[7:0], operand[7:0], expected[7:0], ovf}
    localparam logic [27:0] VEC [NV] = '{
        {3'b001, 8'hA3, 8'hFF, 8'h46, 1'b0},  // R4
        {3'b001, 8'h01, 8'hFF, 8'h02, 1'b0},  // R4
        {3'b010, 8'hA3, 8'hFF, 8'h51, 1'b0},  // R5
        {3'b010, 8'h80, 8'h00, 8'h40, 1'b0},  // R5
        {3'b011, 8'hA3, 8'h00, 8'h47, 1'b0},  // R6
        {3'b011, 8'h80, 8'hFF, 8'h01, 1'b0},  // R6
        {3'b100, 8'hA3, 8'hFF, 8'hD1, 1'b0},  // R7
        {3'b100, 8'h01, 8'h00, 8'h80, 1'b0},  // R7
        {3'b101, 8'hFE, 8'h00, 8'hFC, 1'b0},  // R8
        {3'b101, 8'h20, 8'hFF, 8'h40, 1'b0},  // R8
        {3'b110, 8'hFA, 8'h00, 8'hFD, 1'b0},  // R9
        {3'b110, 8'h04, 8'hFF, 8'h02, 1'b0},  // R9
        {3'b110, 8'hA3, 8'h00, 8'hD1, 1'b0},  // R9
        {3'b101, 8'h40, 8'h00, 8'h80, 1'b1},  // R10
        {3'b101, 8'hA3, 8'h00, 8'h46, 1'b1},  // R10
        {3'b101, 8'hE0, 8'h00, 8'hC0, 1'b0},  // R10
        {3'b101, 8'hC0, 8'h00, 8'h80, 1'b0},  // R10
        {3'b101, 8'h80, 8'h00, 8'h00, 1'b1},  // R10
        {3'b000, 8'h11, 8'h5A, 8'h5A, 1'b0},  // R3
        {3'b000, 8'hFF, 8'h00, 8'h00, 1'b0},  // R3
        {3'b111, 8'hA3, 8'h3C, 8'hA3, 1'b0},  // R3
        {3'b111, 8'h00, 8'hFF, 8'h00, 1'b0}   // R3
    };

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'b000, 3'b111: return "R3";
            3'b001: return "R4";
            3'b010: return "R5";
            3'b011: return "R6";
            3'b100: return "R7";
            3'b101: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic step(input logic e, input logic [2:0] o, input logic [W-1:0] d);
        @(negedge clk);
        en = e; op = o; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] er, input logic eo);
        ntests++;
        if (r_q !== er || ovf_q !== eo) begin
            nfail++;
            $display("FAIL %s: r_q=%h ovf_q=%b expected r_q=%h ovf_q=%b",
                     req, r_q, ovf_q, er, eo);
        end
    endtask

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        step(1'b0, 3'b000, '0);
        step(1'b1, 3'b001, 8'hAA);
        check("R1 reset state", 8'h00, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [2:0] vo;
            logic [7:0] vs, vd, ve;
            logic vf;
            {vo, vs, vd, ve, vf} = VEC[i];
            step(1'b1, 3'b000, vs);
            step(1'b1, vo, vd);
            check(req_of(vo), ve, vf);
        end

        // R11: an operation after an overflowing ASL clears the flag; din is ignored
        step(1'b1, 3'b000, 8'h40);
        step(1'b1, 3'b101, 8'h00);
        check("R10 overflow set", 8'h80, 1'b1);
        step(1'b1, 3'b010, 8'hFF);
        check("R11 flag cleared by LSR", 8'h40, 1'b0);
        step(1'b1, 3'b101, 8'h00);
        check("R10 overflow again", 8'h80, 1'b1);
        // R2: with enable low, state holds even for a load with new data
        step(1'b0, 3'b000, 8'h33);
        check("R2 idle load ignored", 8'h80, 1'b1);
        step(1'b0, 3'b011, 8'h33);
        check("R2 idle rotate ignored", 8'h80, 1'b1);
        step(1'b1, 3'b111, 8'h33);
        check("R3 hold clears flag", 8'h80, 1'b0);
        // R9 repeated: a negative value saturates to all ones
        step(1'b1, 3'b000, 8'h80);
        for (int k = 0; k < 7; k++) step(1'b1, 3'b110, 8'h00);
        check("R9 sign fill", 8'hFF, 1'b0);
        // R1: reset takes priority over enable
        step(1'b1, 3'b101, 8'h00);
        rst = 1'b1;
        step(1'b1, 3'b000, 8'h77);
        check("R1 reset over enable", 8'h00, 1'b0);
        rst = 1'b0;
        // R6 full rotation returns the start value
        step(1'b1, 3'b000, 8'hA3);
        for (int k = 0; k < 8; k++) step(1'b1, 3'b011, 8'h00);
        check("R6 full rotation", 8'hA3, 1'b0);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule